// File: doc/BRIEF.md
# Post-Divider Clock Output Stage

This block is the digital back end of a clock-multiplying loop driver. A fast internal clock comes in; that is either the oscillator output or, in bypass mode, one of two reference clocks. An optional divide-by-two can be placed in front of the divider. A single three-bit down counter then produces the output family: a double-rate clock, five identical base-rate clocks for matched fan-out, one base-rate clock of opposite polarity and a half-rate clock. All of these rise together at every counter wrap.

The source choice and the prescaler choice are sampled continuously while reset is low. Once running, they are reloaded only at a counter wrap, so a change never cuts a pulse short. An asynchronous active-low reset clears the divider. While reset is low, every clock output is high-impedance. The `out_en` pin mirrors the drive state so that a test environment can observe it.

Top module: `clkout_stage`

## Requirements
- R1: In bypass mode, `ref_pick` = 1 makes `ref_b_clk` drive the divider and `ref_pick` = 0 makes `ref_a_clk` drive it.
- R2: `pll_on` = 1 makes `osc_clk` drive the divider; `pll_on` = 0 bypasses the oscillator in favour of the selected reference.
- R3: With `prediv_on` = 0 the base outputs have a period of 4 source-clock periods; with `prediv_on` = 1 the period is 8.
- R4: `o_dbl` has half the base period, and every rising edge of `o_base` coincides with a rising edge of `o_dbl`.
- R5: `o_half` has twice the base period, and each of its rising edges coincides with rising edges of `o_base` and `o_dbl`.
- R6: From the first divider step after reset, `o_base_n` is always the complement of `o_base`.
- R7: While `rst_n` is low, all clock outputs are high-impedance and `out_en` is 0, taking effect without any clock edge. Once `rst_n` goes high, `out_en` is 1 and every clock output reads 0 until the first divider step.
- R8: All `NUM_BASE` lanes of `o_base` carry the same value at all times.
- R9: After reset release, the first rising edges of `o_dbl`, `o_base` and `o_half` occur together. They fall on the first source rising edge, or on the second when `prediv_on` = 1.
- R10: A change to `pll_on`, `ref_pick` or `prediv_on` while running takes effect only at the next counter wrap, which is the edge where `o_half` rises. The wrap cycle in progress finishes at the old rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock |
| ref_a_clk | input | 1 | First reference clock |
| ref_b_clk | input | 1 | Second reference clock |
| ref_pick | input | 1 | Reference choice: 1 = ref_b_clk, 0 = ref_a_clk |
| pll_on | input | 1 | 1 = oscillator drives divider, 0 = reference bypass |
| prediv_on | input | 1 | 1 = insert divide-by-two before the divider |
| rst_n | input | 1 | Asynchronous active-low reset and output disable |
| o_dbl | output | 1 | Double-rate clock |
| o_base | output | NUM_BASE | Matched base-rate clocks |
| o_base_n | output | 1 | Base-rate clock of opposite polarity |
| o_half | output | 1 | Half-rate clock |
| out_en | output | 1 | 1 while the clock outputs are driven |

## Verification
The entry into reset is checked 1 ns after `rst_n` falls, with no clock edge in between. The cleared outputs are checked 1 ns after release. Release is placed on a falling edge of the chosen source, so the first step lands exactly half a source period later, or one and a half periods with the prescaler; the first-edge times are compared against those values. Periods and alignment are read from recorded rising-edge times once the second `o_half` rise has occurred. For the mid-run prescaler change, the check expects the two base rises after the change at 4 and 8 old-rate periods, and the following rise 8 more periods later.

// File: rtl/clkout_pkg.sv
`timescale 1ns/1ps
package clkout_pkg;
  localparam int DIV_W    = 3;
  localparam int DBL_BIT  = 0;
  localparam int BASE_BIT = 1;
  localparam int HALF_BIT = DIV_W - 1;

  typedef struct packed {
    logic pll_on;
    logic ref_pick;
    logic prediv_on;
  } src_cfg_t;
endpackage

// File: rtl/clkout_src.sv
`timescale 1ns/1ps
module clkout_src
  import clkout_pkg::*;
(
  input  logic     osc_clk,
  input  logic     ref_a_clk,
  input  logic     ref_b_clk,
  input  src_cfg_t live_cfg,
  input  logic     armed,
  input  logic     wrap,
  output src_cfg_t cfg_q,
  output logic     core_clk
);
  src_cfg_t sel;
  logic     ref_clk;

  // Before the first step the live pins steer the mux; afterwards the held copy does.
  assign sel      = armed ? cfg_q : live_cfg;
  assign ref_clk  = sel.ref_pick ? ref_b_clk : ref_a_clk;
  assign core_clk = sel.pll_on ? osc_clk : ref_clk;

  // Reload only while idle or at a wrap, so no pulse is ever shortened.
  always_ff @(posedge core_clk) begin
    if (!armed || wrap) cfg_q <= live_cfg;
  end
endmodule

// File: rtl/clkout_div.sv
`timescale 1ns/1ps
module clkout_div
  import clkout_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic prediv_on,
  output logic dbl_q,
  output logic base_q,
  output logic base_n_q,
  output logic half_q,
  output logic wrap,
  output logic armed
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_d;
  logic             pre_q;
  logic             inv_q;
  logic             tick;

  // A down counter from zero sets every bit together at each wrap.
  assign tick  = !prediv_on || pre_q;
  assign cnt_d = cnt_q - DIV_W'(1);
  assign wrap  = tick && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pre_q <= 1'b0;
      inv_q <= 1'b0;
      armed <= 1'b0;
    end else begin
      armed <= 1'b1;
      pre_q <= prediv_on ? ~pre_q : 1'b0;
      if (tick) begin
        cnt_q <= cnt_d;
        inv_q <= ~cnt_d[BASE_BIT];
      end
    end
  end

  assign dbl_q    = cnt_q[DBL_BIT];
  assign base_q   = cnt_q[BASE_BIT];
  assign half_q   = cnt_q[HALF_BIT];
  assign base_n_q = inv_q;
endmodule

// File: rtl/clkout_drv.sv
`timescale 1ns/1ps
module clkout_drv #(
  parameter int NUM_BASE = 5
) (
  input  logic                drive,
  input  logic                dbl_q,
  input  logic                base_q,
  input  logic                base_n_q,
  input  logic                half_q,
  output logic                o_dbl,
  output logic [NUM_BASE-1:0] o_base,
  output logic                o_base_n,
  output logic                o_half
);
  assign o_dbl    = drive ? dbl_q    : 1'bz;
  assign o_base_n = drive ? base_n_q : 1'bz;
  assign o_half   = drive ? half_q   : 1'bz;

  for (genvar g = 0; g < NUM_BASE; g++) begin : g_lane
    assign o_base[g] = drive ? base_q : 1'bz;
  end
endmodule

// File: rtl/clkout_stage.sv
`timescale 1ns/1ps
module clkout_stage
  import clkout_pkg::*;
#(
  parameter int NUM_BASE = 5
) (
  input  logic                osc_clk,
  input  logic                ref_a_clk,
  input  logic                ref_b_clk,
  input  logic                ref_pick,
  input  logic                pll_on,
  input  logic                prediv_on,
  input  logic                rst_n,
  output logic                o_dbl,
  output logic [NUM_BASE-1:0] o_base,
  output logic                o_base_n,
  output logic                o_half,
  output logic                out_en
);
  src_cfg_t live_cfg;
  src_cfg_t cfg_q;
  logic     core_clk;
  logic     armed;
  logic     wrap;
  logic     dbl_q, base_q, base_n_q, half_q;

  assign live_cfg = '{pll_on: pll_on, ref_pick: ref_pick, prediv_on: prediv_on};
  assign out_en   = rst_n;

  clkout_src u_src (
    .osc_clk  (osc_clk),
    .ref_a_clk(ref_a_clk),
    .ref_b_clk(ref_b_clk),
    .live_cfg (live_cfg),
    .armed    (armed),
    .wrap     (wrap),
    .cfg_q    (cfg_q),
    .core_clk (core_clk)
  );

  clkout_div u_div (
    .clk      (core_clk),
    .rst_n    (rst_n),
    .prediv_on(armed ? cfg_q.prediv_on : live_cfg.prediv_on),
    .dbl_q    (dbl_q),
    .base_q   (base_q),
    .base_n_q (base_n_q),
    .half_q   (half_q),
    .wrap     (wrap),
    .armed    (armed)
  );

  clkout_drv #(.NUM_BASE(NUM_BASE)) u_drv (
    .drive   (rst_n),
    .dbl_q   (dbl_q),
    .base_q  (base_q),
    .base_n_q(base_n_q),
    .half_q  (half_q),
    .o_dbl   (o_dbl),
    .o_base  (o_base),
    .o_base_n(o_base_n),
    .o_half  (o_half)
  );
endmodule

// File: rtl/clkout_stage_chk.sv
`timescale 1ns/1ps
module clkout_stage_chk #(
  parameter int NUM_BASE = 5
) (
  input logic                core_clk,
  input logic                rst_n,
  input logic                wrap,
  input logic [2:0]          cfg,
  input logic                dbl_q,
  input logic                base_q,
  input logic                base_n_q,
  input logic                half_q,
  input logic [NUM_BASE-1:0] o_base
);
  logic started_q;
  always_ff @(posedge core_clk or negedge rst_n) begin
    if (!rst_n)     started_q <= 1'b0;
    else if (dbl_q) started_q <= 1'b1;
  end

  AST_HALF_ALIGNED: assert property (@(posedge core_clk) disable iff (!rst_n)
    $rose(half_q) |-> ($rose(base_q) && $rose(dbl_q))); // R5
  AST_BASE_ON_DBL: assert property (@(posedge core_clk) disable iff (!rst_n)
    $rose(base_q) |-> $rose(dbl_q)); // R4
  AST_BASE_N_OPPOSITE: assert property (@(posedge core_clk) disable iff (!rst_n)
    (started_q || dbl_q) |-> (base_n_q != base_q)); // R6
  AST_CFG_ONLY_AT_WRAP: assert property (@(posedge core_clk) disable iff (!rst_n)
    (started_q && !wrap) |=> $stable(cfg)); // R10
  AST_LANES_MATCHED: assert property (@(posedge core_clk) disable iff (!rst_n)
    o_base == {NUM_BASE{o_base[0]}}); // R8
endmodule

bind clkout_stage clkout_stage_chk #(.NUM_BASE(NUM_BASE)) u_chk (
  .core_clk(core_clk),
  .rst_n   (rst_n),
  .wrap    (wrap),
  .cfg     (cfg_q),
  .dbl_q   (dbl_q),
  .base_q  (base_q),
  .base_n_q(base_n_q),
  .half_q  (half_q),
  .o_base  (o_base)
);

// File: tb/clkout_stage_bench.sv
`timescale 1ns/1ps
module clkout_stage_bench;
  localparam int CLK_PERIOD = 10;
  localparam int REFA_T     = 40;
  localparam int REFB_T     = 60;
  localparam int NB         = 5;

  logic osc_clk = 0, ref_a_clk = 0, ref_b_clk = 0;
  logic ref_pick = 0, pll_on = 1, prediv_on = 0, rst_n = 0;
  logic o_dbl, o_base_n, o_half, out_en;
  logic [NB-1:0] o_base;

  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) osc_clk = ~osc_clk;
  always #(REFA_T/2) ref_a_clk = ~ref_a_clk;
  always #(REFB_T/2) ref_b_clk = ~ref_b_clk;

  clkout_stage #(.NUM_BASE(NB)) u_clkout_stage (
    .osc_clk(osc_clk), .ref_a_clk(ref_a_clk), .ref_b_clk(ref_b_clk),
    .ref_pick(ref_pick), .pll_on(pll_on), .prediv_on(prediv_on), .rst_n(rst_n),
    .o_dbl(o_dbl), .o_base(o_base), .o_base_n(o_base_n), .o_half(o_half),
    .out_en(out_en)
  );

  // Rising-edge recorders
  int  n_dbl, n_base, n_half;
  time dbl_first, dbl_last, dbl_prev;
  time base_first, base_last, base_prev;
  time half_first, half_last, half_prev;

  always @(posedge o_dbl) if (rst_n) begin
    n_dbl++; dbl_prev = dbl_last; dbl_last = $time;
    if (n_dbl == 1) dbl_first = $time;
  end
  always @(posedge o_base[0]) if (rst_n) begin
    n_base++; base_prev = base_last; base_last = $time;
    if (n_base == 1) base_first = $time;
  end
  always @(posedge o_half) if (rst_n) begin
    n_half++; half_prev = half_last; half_last = $time;
    if (n_half == 1) half_first = $time;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wait_src_negedge(input bit pll, input bit pick);
    if (pll)       @(negedge osc_clk);
    else if (pick) @(negedge ref_b_clk);
    else           @(negedge ref_a_clk);
  endtask

  // One full scenario: reset, release, first edges, periods, alignment, lanes.
  task automatic run_case(input bit pll, input bit pick, input bit pre,
                          input int ts, input string req_src);
    time t_rel, t_first;
    int  tb;
    rst_n = 0; pll_on = pll; ref_pick = pick; prediv_on = pre;
    #(ts*4);
    chk(out_en == 1'b0, "R7", "out_en while held in reset", out_en, 0);
    wait_src_negedge(pll, pick);
    n_dbl = 0; n_base = 0; n_half = 0;
    rst_n = 1; t_rel = $time;
    #1;
    chk({o_dbl, o_base, o_base_n, o_half} == '0, "R7", "outputs cleared after release",
        {o_dbl, o_base, o_base_n, o_half}, 0);
    chk(out_en == 1'b1, "R7", "out_en after release", out_en, 1);
    wait (n_half >= 2);
    #1;
    tb      = 4 * ts * (pre ? 2 : 1);
    t_first = t_rel + ts/2 + (pre ? ts : 0);
    chk(dbl_first == t_first, "R9", "first o_dbl rise", dbl_first, t_first);
    chk(base_first == t_first, "R9", "first o_base rise", base_first, t_first);
    chk(half_first == t_first, "R9", "first o_half rise", half_first, t_first);
    chk(base_last - base_prev == tb, pre ? "R3" : req_src, "base period",
        base_last - base_prev, tb);
    chk(dbl_last - dbl_prev == tb/2, "R4", "double-rate period", dbl_last - dbl_prev, tb/2);
    chk(half_last - half_prev == 2*tb, "R5", "half-rate period", half_last - half_prev, 2*tb);
    chk(base_last == half_last && dbl_last == half_last, "R5", "edge alignment at half rise",
        base_last, half_last);
    chk(o_base_n == ~o_base[0], "R6", "inverted output while base high", o_base_n, ~o_base[0]);
    chk(o_base == {NB{o_base[0]}}, "R8", "lanes match while high", o_base, {NB{o_base[0]}});
    #(tb/2);
    chk(o_base_n == ~o_base[0], "R6", "inverted output while base low", o_base_n, ~o_base[0]);
    chk(o_base == {NB{o_base[0]}}, "R8", "lanes match while low", o_base, {NB{o_base[0]}});
  endtask

  task automatic test_reset_state;
    #1;
    chk(out_en == 1'b0, "R7", "out_en at start", out_en, 0);
  endtask

  // r10_: prescaler change mid-run lands only at the next wrap
  task automatic test_change_at_wrap;
    int  h0, nb0;
    time t0;
    run_case(1, 0, 0, CLK_PERIOD, "R2");
    h0 = n_half;
    wait (n_half > h0);
    #1;
    t0 = half_last; nb0 = n_base;
    prediv_on = 1;
    wait (n_base >= nb0 + 3);
    #1;
    chk(base_prev == t0 + 8*CLK_PERIOD, "R10", "wrap rise at old rate",
        base_prev - t0, 8*CLK_PERIOD);
    chk(base_last == t0 + 16*CLK_PERIOD, "R10", "first rise at new rate",
        base_last - t0, 16*CLK_PERIOD);
  endtask

  task automatic test_async_reset;
    @(posedge osc_clk);
    #3;
    rst_n = 0;
    #1;
    chk(out_en == 1'b0, "R7", "out_en drops without a clock edge", out_en, 0);
  endtask

  initial begin
    test_reset_state();
    run_case(1, 0, 0, CLK_PERIOD, "R2");  // oscillator, no prescaler
    run_case(1, 0, 1, CLK_PERIOD, "R2");  // R3 prescaler on
    run_case(0, 0, 0, REFA_T, "R1");      // R2 bypass, first reference
    run_case(0, 1, 0, REFB_T, "R1");      // bypass, second reference
    run_case(0, 1, 1, REFB_T, "R1");      // bypass with prescaler
    test_change_at_wrap();
    test_async_reset();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule